// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front-End

This block is the bus side of a small serial memory slave on a two-wire (I2C-style) bus. It samples the clock and data lines and removes short glitches. It finds bus start and stop events, shifts 8-bit words in and out most significant bit first, and pulls the data line low to acknowledge. Toward the memory array it has a byte-wide handshake. Received bytes come out as one-cycle pulses, and the first byte after the address is flagged so the array can load its word pointer. A one-cycle request pulse fetches each byte to send.

The data line is never driven high. The block only asserts an open-drain pull-down enable. A change on that enable is placed a fixed number of clocks after the filtered clock falls, so output data settles inside the clock-low window. A completed write starts an internal busy interval, and the slave refuses its own address while that interval lasts. A stop that closes a read session puts the block into standby.

Top module: `twi_mem_front`

## Requirements
- R1: A pulse shorter than FILT_CYC clock periods on either line is ignored. It never counts as a clock edge, a start or a stop.
- R2: After reset and after any stop, nothing is acknowledged and no byte is reported until a start is seen.
- R3: A start (SDA falling while SCL is high) begins a new transfer in any state. Bits already shifted are dropped, and the next 8 bits are taken as an address.
- R4: The first byte after a start carries the 7-bit DEV_ADDR in bits 7..1, most significant bit first. Bit 0 = 1 selects read and 0 selects write. On a mismatch there is no acknowledge and the bus is ignored until the next start.
- R5: After a matched address and after each byte received in a write, sda_oe is high across the ninth SCL clock. At no other time is it high, except while sending read data.
- R6: sda_oe changes only while SCL is low.
- R7: Every sda_oe change comes OUT_DLY cycles after the filtered SCL fall. With the default settings at 50 MHz this is between 5 and 45 clocks after SCL falls at the pin.
- R8: In a read, tx_req pulses for one cycle and tx_data is taken in that same cycle. The byte is sent MSB first, with sda_oe = 1 for a 0 bit. A host acknowledge (SDA low on the ninth clock) fetches the next byte. A host no-acknowledge releases the line and stops further tx_req pulses.
- R9: A stop that ends a read session sets standby. The next start clears it.
- R10: A stop after at least one memory data byte was written holds busy high for exactly BUSY_CYC cycles. While busy is high, the address is not acknowledged and no byte is reported.
- R11: A stop in the middle of a byte drops that byte. It is never reported and does not start a write cycle.
- R12: Each complete byte after a write address gives one single-cycle rx_valid pulse with rx_data. rx_first is 1 only for the first such byte after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | Pull-down enable for the data line (1 = drive low) |
| rx_valid | output | 1 | One-cycle pulse: received byte on rx_data |
| rx_data | output | 8 | Received byte |
| rx_first | output | 1 | Marks the first byte after the address |
| tx_req | output | 1 | One-cycle request: tx_data is taken in this cycle |
| tx_data | input | 8 | Byte to send, valid while tx_req is high |
| busy | output | 1 | Internal write cycle in progress |
| standby | output | 1 | Low-power idle after a read |

## Verification
The bench attacks the edges of a transfer. It sends bytes with no start, aborts a byte halfway with a stop or a repeated start, and addresses the slave during its write interval. A design that missed these would acknowledge a headless byte, report a partial write, or answer while busy. It injects sub-threshold pulses on SCL inside a data byte and on SDA with SCL high. An unfiltered design would shift an extra bit or take a false start. A random read with a repeated start checks the MSB-first order and the stop after a host no-acknowledge. Every change of the pull-down enable is timed against the clock fall, which exposes a design that drives during SCL high or changes its output too early or too late.

// File: rtl/twi_pkg.sv
package twi_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      TW_IDLE,
      TW_RECV,
      TW_ACK,
      TW_SEND,
      TW_HOSTACK
   } tw_state_e;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
   parameter int SYNC_STG = 2,
   parameter int FILT_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic clean_o
);
   logic [SYNC_STG-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STG-2:0], raw_i};
   end

   generate
      if (FILT_CYC == 0) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clean_o <= 1'b1;
            else        clean_o <= sync_q[SYNC_STG-1];
         end
      end else begin : g_persist
         localparam int CW = $clog2(FILT_CYC + 1);
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clean_o <= 1'b1;
               run_q   <= '0;
            end else if (sync_q[SYNC_STG-1] != clean_o) begin
               if (run_q == CW'(FILT_CYC - 1)) begin
                  clean_o <= sync_q[SYNC_STG-1];
                  run_q   <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end else begin
               run_q <= '0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise = scl_f & ~scl_q;
   assign scl_fall = ~scl_f & scl_q;
   assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/twi_slave_engine.sv
module twi_slave_engine
   import twi_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h50,
   parameter int         BUSY_CYC = 250000,
   parameter int         OUT_DLY  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              sda_in,
   input  logic [BYTE_W-1:0] tx_data,
   output logic              sda_oe,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_first,
   output logic              tx_req,
   output logic              busy,
   output logic              standby
);
   localparam int BW = $clog2(BUSY_CYC + 1);
   localparam int DW = $clog2(OUT_DLY + 1);

   tw_state_e         state_q;
   logic [3:0]        bitcnt_q;
   logic [BYTE_W-1:0] shreg_q;
   logic              is_addr_q, rw_q, first_q, wr_sess_q, rd_sess_q, mnack_q;
   logic [BW-1:0]     busy_cnt_q;
   logic              standby_q, oe_q, oe_nxt_q, pend_q;
   logic [DW-1:0]     dly_q;
   logic              rxv_q, rxf_q;
   logic [BYTE_W-1:0] rxd_q;

   assign busy     = (busy_cnt_q != '0);
   assign standby  = standby_q;
   assign sda_oe   = oe_q;
   assign rx_valid = rxv_q;
   assign rx_data  = rxd_q;
   assign rx_first = rxf_q;
   assign tx_req   = scl_fall && ((state_q == TW_ACK && rw_q) ||
                                  (state_q == TW_HOSTACK && !mnack_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= TW_IDLE;
         bitcnt_q   <= '0;
         shreg_q    <= '0;
         is_addr_q  <= 1'b0;
         rw_q       <= 1'b0;
         first_q    <= 1'b0;
         wr_sess_q  <= 1'b0;
         rd_sess_q  <= 1'b0;
         mnack_q    <= 1'b1;
         busy_cnt_q <= '0;
         standby_q  <= 1'b0;
         oe_q       <= 1'b0;
         oe_nxt_q   <= 1'b0;
         pend_q     <= 1'b0;
         dly_q      <= '0;
         rxv_q      <= 1'b0;
         rxf_q      <= 1'b0;
         rxd_q      <= '0;
      end else begin
         rxv_q <= 1'b0;
         if (busy_cnt_q != '0) busy_cnt_q <= busy_cnt_q - 1'b1;
         if (pend_q) begin
            if (dly_q == DW'(OUT_DLY - 1)) begin
               oe_q   <= oe_nxt_q;
               pend_q <= 1'b0;
            end else begin
               dly_q <= dly_q + 1'b1;
            end
         end

         if (start_ev) begin
            state_q   <= TW_RECV;
            bitcnt_q  <= '0;
            is_addr_q <= 1'b1;
            standby_q <= 1'b0;
            wr_sess_q <= 1'b0;
            rd_sess_q <= 1'b0;
            oe_q      <= 1'b0;
            pend_q    <= 1'b0;
         end else if (stop_ev) begin
            state_q   <= TW_IDLE;
            oe_q      <= 1'b0;
            pend_q    <= 1'b0;
            if (wr_sess_q)      busy_cnt_q <= BW'(BUSY_CYC);
            else if (rd_sess_q) standby_q  <= 1'b1;
            wr_sess_q <= 1'b0;
            rd_sess_q <= 1'b0;
         end else begin
            case (state_q)
               TW_RECV: begin
                  if (scl_rise) begin
                     shreg_q  <= {shreg_q[BYTE_W-2:0], sda_in};
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end else if (scl_fall && bitcnt_q == 4'd8) begin
                     if (is_addr_q) begin
                        if (shreg_q[7:1] == DEV_ADDR && !busy) begin
                           rw_q      <= shreg_q[0];
                           rd_sess_q <= shreg_q[0];
                           first_q   <= 1'b1;
                           state_q   <= TW_ACK;
                           pend_q    <= 1'b1;
                           dly_q     <= '0;
                           oe_nxt_q  <= 1'b1;
                        end else begin
                           state_q <= TW_IDLE;
                        end
                     end else begin
                        rxv_q    <= 1'b1;
                        rxd_q    <= shreg_q;
                        rxf_q    <= first_q;
                        first_q  <= 1'b0;
                        if (!first_q) wr_sess_q <= 1'b1;
                        state_q  <= TW_ACK;
                        pend_q   <= 1'b1;
                        dly_q    <= '0;
                        oe_nxt_q <= 1'b1;
                     end
                  end
               end
               TW_ACK: begin
                  if (scl_fall) begin
                     bitcnt_q  <= '0;
                     is_addr_q <= 1'b0;
                     pend_q    <= 1'b1;
                     dly_q     <= '0;
                     if (rw_q) begin
                        state_q  <= TW_SEND;
                        shreg_q  <= tx_data;
                        oe_nxt_q <= ~tx_data[BYTE_W-1];
                     end else begin
                        state_q  <= TW_RECV;
                        oe_nxt_q <= 1'b0;
                     end
                  end
               end
               TW_SEND: begin
                  if (scl_fall) begin
                     pend_q <= 1'b1;
                     dly_q  <= '0;
                     if (bitcnt_q == 4'd7) begin
                        state_q  <= TW_HOSTACK;
                        oe_nxt_q <= 1'b0;
                     end else begin
                        bitcnt_q <= bitcnt_q + 1'b1;
                        shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
                        oe_nxt_q <= ~shreg_q[BYTE_W-2];
                     end
                  end
               end
               TW_HOSTACK: begin
                  if (scl_rise) begin
                     mnack_q <= sda_in;
                  end else if (scl_fall) begin
                     bitcnt_q <= '0;
                     if (!mnack_q) begin
                        state_q  <= TW_SEND;
                        shreg_q  <= tx_data;
                        pend_q   <= 1'b1;
                        dly_q    <= '0;
                        oe_nxt_q <= ~tx_data[BYTE_W-1];
                     end else begin
                        state_q <= TW_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/twi_mem_front.sv
module twi_mem_front
   import twi_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h50,
   parameter int         SYNC_STG = 2,
   parameter int         FILT_CYC = 3,
   parameter int         OUT_DLY  = 3,
   parameter int         BUSY_CYC = 250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_first,
   output logic              tx_req,
   input  logic [BYTE_W-1:0] tx_data,
   output logic              busy,
   output logic              standby
);
   localparam int N_LINES = 2;

   initial begin
      if (SYNC_STG < 2) $error("twi_mem_front: SYNC_STG must be at least 2");
      if (FILT_CYC < 0) $error("twi_mem_front: FILT_CYC must not be negative");
      if (OUT_DLY < 1)  $error("twi_mem_front: OUT_DLY must be at least 1");
      if (BUSY_CYC < 1) $error("twi_mem_front: BUSY_CYC must be at least 1");
   end

   logic [N_LINES-1:0] raw_lines, clean_lines;
   logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;

   assign raw_lines = {sda_i, scl_i};
   assign scl_f     = clean_lines[0];
   assign sda_f     = clean_lines[1];

   generate
      for (genvar li = 0; li < N_LINES; li++) begin : g_line
         twi_line_filter #(
            .SYNC_STG(SYNC_STG),
            .FILT_CYC(FILT_CYC)
         ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[li]),
            .clean_o(clean_lines[li])
         );
      end
   endgenerate

   twi_bus_events u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (scl_f),
      .sda_f   (sda_f),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .start_ev(start_ev),
      .stop_ev (stop_ev)
   );

   twi_slave_engine #(
      .DEV_ADDR(DEV_ADDR),
      .BUSY_CYC(BUSY_CYC),
      .OUT_DLY (OUT_DLY)
   ) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .start_ev(start_ev),
      .stop_ev (stop_ev),
      .sda_in  (sda_f),
      .tx_data (tx_data),
      .sda_oe  (sda_oe),
      .rx_valid(rx_valid),
      .rx_data (rx_data),
      .rx_first(rx_first),
      .tx_req  (tx_req),
      .busy    (busy),
      .standby (standby)
   );
endmodule

// File: rtl/twi_mem_front_chk.sv
module twi_mem_front_chk #(
   parameter int BUSY_CYC = 250000
) (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_oe,
   input logic rx_valid,
   input logic tx_req,
   input logic busy,
   input logic standby
);
   int unsigned busy_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run_q <= 0;
      else if (busy) busy_run_q <= busy_run_q + 1;
      else           busy_run_q <= 0;
   end

   p_rx_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_txreq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |=> !tx_req);

   p_no_rx_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !busy);

   p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_run_q == BUSY_CYC);

   p_oe_rise_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);

   p_standby_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(standby && busy));
endmodule

bind twi_mem_front twi_mem_front_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_i   (scl_i),
   .sda_oe  (sda_oe),
   .rx_valid(rx_valid),
   .tx_req  (tx_req),
   .busy    (busy),
   .standby (standby)
);

// File: tb/tb_twi_mem_front.sv
module tb_twi_mem_front;
   localparam int Q    = 20;
   localparam int BUSY = 2000;

   logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
   logic sda_oe, rx_valid, rx_first, tx_req, busy, standby;
   logic [7:0] rx_data, tx_data;
   wire sda_line = sda_m & ~sda_oe;

   always #10 clk = ~clk;

   twi_mem_front #(.DEV_ADDR(7'h50), .BUSY_CYC(BUSY)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_first(rx_first), .tx_req(tx_req), .tx_data(tx_data),
      .busy(busy), .standby(standby));

   int n_chk = 0, n_err = 0, n_tx = 0, lag = 0;
   int unsigned cyc = 0;
   bit done = 0, may_drive = 0, oe_prev = 0, scl_prev = 1;
   logic [8:0] rxq[$];
   logic [7:0] mem [256];
   logic [7:0] ptr;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory array model on the byte handshake
   assign tx_data = mem[ptr];
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
         ptr <= 8'h00;
      end else if (rx_valid) begin
         if (rx_first) ptr <= rx_data;
         else begin mem[ptr] <= rx_data; ptr <= ptr + 8'd1; end
      end else if (tx_req) ptr <= ptr + 8'd1;
   end

   // per-clock observation of outputs
   always @(negedge clk) begin
      #1;
      if (rx_valid) rxq.push_back({rx_first, rx_data});
      if (tx_req) n_tx++;
      if (scl_prev && !scl_m) lag = 0; else lag++;
      scl_prev = scl_m;
      if (rst_n && sda_oe != oe_prev) begin
         chk(scl_m == 1'b0, "R6 oe change with SCL low", scl_m, 0);
         chk(lag >= 5 && lag <= 45, "R7 oe change delay", lag, 9);
         if (sda_oe) chk(may_drive, "R5 oe only in ack/read window", may_drive, 1);
      end
      oe_prev = sda_oe;
   end

   task automatic wq(input int n); repeat (n) @(negedge clk); endtask

   task automatic clk_bit(input logic b, input bit glitch, output logic line);
      sda_m = b;
      if (glitch) begin
         wq(Q/2); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(Q/2 - 2);
      end else wq(Q);
      scl_m = 1'b1; wq(Q);
      line = sda_line;
      wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input int gbit, output bit ack);
      logic l;
      for (int i = 7; i >= 0; i--) begin
         if (i == 0) may_drive = 1;
         clk_bit(b[i], (i == gbit), l);
      end
      clk_bit(1'b1, 0, l);
      ack = !l;
      may_drive = 0;
   endtask

   task automatic recv_byte(input logic hnack, output logic [7:0] b);
      logic l;
      may_drive = 1;
      for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, 0, l); b[i] = l; end
      clk_bit(hnack, 0, l);
      if (hnack) may_drive = 0;
   endtask

   task automatic expect_rx(input logic [8:0] e, input string tag);
      if (rxq.size() == 0) chk(0, tag, 9'h1ff, e);
      else begin
         logic [8:0] g;
         g = rxq.pop_front();
         chk(g == e, tag, g, e);
      end
   endtask

   initial begin
      bit ack;
      logic [7:0] rd;
      int unsigned t0;
      wq(5); rst_n = 1'b1; wq(10);
      chk(sda_oe == 0, "R5 reset oe", sda_oe, 0);
      chk(busy == 0, "R10 reset busy", busy, 0);
      chk(standby == 0, "R9 reset standby", standby, 0);
      chk(rx_valid == 0 && tx_req == 0, "R12 reset handshake", rx_valid, 0);

      // R2: byte without a start
      scl_m = 1'b0; wq(Q);
      send_byte(8'hA0, -1, ack);
      chk(!ack, "R2 no ack before start", ack, 0);
      scl_m = 1'b1; wq(2*Q);
      chk(rxq.size() == 0, "R2 nothing reported", rxq.size(), 0);

      // write: address, word address, two data bytes
      bus_start;
      send_byte(8'hA0, -1, ack); chk(ack, "R5 address ack", ack, 1);
      send_byte(8'h03, -1, ack); chk(ack, "R5 word ack", ack, 1);
      send_byte(8'h5A, -1, ack); chk(ack, "R5 data ack", ack, 1);
      send_byte(8'hC3, -1, ack); chk(ack, "R5 data ack 2", ack, 1);
      expect_rx({1'b1, 8'h03}, "R12 first byte flagged");
      expect_rx({1'b0, 8'h5A}, "R4 data MSB first");
      expect_rx({1'b0, 8'hC3}, "R12 second data byte");
      bus_stop;
      t0 = cyc;
      chk(busy == 1, "R10 busy after write stop", busy, 1);
      chk(standby == 0, "R9 no standby after write", standby, 0);

      // address during busy
      bus_start;
      send_byte(8'hA0, -1, ack); chk(!ack, "R10 nack while busy", ack, 0);
      bus_stop;
      while (cyc < t0 + BUSY - 100) wq(1);
      chk(busy == 1, "R10 busy held", busy, 1);
      while (cyc < t0 + BUSY + 50) wq(1);
      chk(busy == 0, "R10 busy ends", busy, 0);

      // foreign address
      bus_start;
      send_byte(8'hA2, -1, ack); chk(!ack, "R4 wrong address nack", ack, 0);
      send_byte(8'h11, -1, ack); chk(!ack, "R4 ignored after mismatch", ack, 0);
      bus_stop;
      chk(rxq.size() == 0, "R4 nothing reported", rxq.size(), 0);

      // random read with repeated start
      bus_start;
      send_byte(8'hA0, -1, ack); chk(ack, "R5 read setup ack", ack, 1);
      send_byte(8'h03, -1, ack);
      expect_rx({1'b1, 8'h03}, "R12 pointer byte");
      bus_start;
      send_byte(8'hA1, -1, ack); chk(ack, "R4 read address ack", ack, 1);
      recv_byte(1'b0, rd); chk(rd == 8'h5A, "R8 first read byte", rd, 8'h5A);
      recv_byte(1'b1, rd); chk(rd == 8'hC3, "R8 second read byte", rd, 8'hC3);
      wq(Q);
      chk(n_tx == 2, "R8 no fetch after nack", n_tx, 2);
      chk(sda_oe == 0, "R8 released after nack", sda_oe, 0);
      bus_stop;
      chk(standby == 1, "R9 standby after read", standby, 1);
      chk(busy == 0, "R10 no busy after read", busy, 0);

      // stop in the middle of a byte
      bus_start;
      chk(standby == 0, "R9 start clears standby", standby, 1'b0);
      send_byte(8'hA0, -1, ack);
      send_byte(8'h05, -1, ack);
      expect_rx({1'b1, 8'h05}, "R11 word byte before abort");
      begin logic l; clk_bit(1, 0, l); clk_bit(0, 0, l); clk_bit(1, 0, l); end
      bus_stop;
      wq(Q);
      chk(rxq.size() == 0, "R11 partial byte dropped", rxq.size(), 0);
      chk(busy == 0, "R11 no write cycle", busy, 0);

      // repeated start in the middle of a byte
      bus_start;
      begin logic l; clk_bit(0, 0, l); clk_bit(1, 0, l); clk_bit(1, 0, l); end
      bus_start;
      send_byte(8'hA0, -1, ack); chk(ack, "R3 restart realigns", ack, 1);
      bus_stop;

      // SDA glitch with SCL high must not be a start
      sda_m = 1'b0; wq(2); sda_m = 1'b1; wq(Q);
      scl_m = 1'b0; wq(Q);
      send_byte(8'hA0, -1, ack); chk(!ack, "R1 SDA glitch not a start", ack, 0);
      scl_m = 1'b1; wq(2*Q);

      // SCL glitch inside a data byte
      bus_start;
      send_byte(8'hA0, -1, ack);
      send_byte(8'h10, -1, ack);
      send_byte(8'h96, 3, ack); chk(ack, "R1 ack despite SCL glitch", ack, 1);
      expect_rx({1'b1, 8'h10}, "R1 word byte");
      expect_rx({1'b0, 8'h96}, "R1 glitched byte intact");
      bus_stop;
      chk(busy == 1, "R10 second write busy", busy, 1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule